// File: doc/BRIEF.md
# Scoreboard Read/Write Go Arbiter

This block holds the per-unit request and grant state that sits between the dependency matrix of a scoreboard-style out-of-order core and its function units. Each function unit reports an issue pulse, a completion pulse, and two vectors of pending dependencies: one for operand reads and one for the result write. From these the block builds a read request and a write request for every unit. It passes each set of requests to its own lowest-index-first picker, and it drives a one-hot read grant vector and a one-hot write grant vector.

Each unit keeps two release flags. Both are armed by the rising edge of its issue line and both are cleared by the matching grant. As a result, every issued instruction receives exactly one read grant and exactly one write grant, however long the unit stays busy. A unit with no dependencies that runs for many cycles cannot hold the read picker, so lower-priority units still receive their grants. The busy flag of a unit is set by issue and is cleared by completion, but only once the write grant has been given.

Top module: `sb_go_arbiter`

## Requirements
- R1: A unit requests a read only when every bit of its read-dependency vector is zero. A single set bit withholds its read grant.
- R2: A unit whose busy flag is low never receives a read grant or a write grant. `busy_o` rises in the cycle after the issue edge, so no grant can occur in the issue cycle itself.
- R3: When several units request at once, each grant goes to the requesting unit with the lowest index, and only requesting units receive grants.
- R4: In every cycle, `go_rd_o` and `go_wr_o` each have at most one bit set.
- R5: After a unit has received one read grant, it receives no further read grant while it stays busy, unless a new issue edge arrives. Each read grant therefore lasts one clock.
- R6: A unit requests a write only while busy, with its write release flag armed and every bit of its write-dependency vector zero. It receives one write grant per issue.
- R7: The release flags are armed only by a rising edge of the issue line. Holding issue high for several cycles re-arms them once.
- R8: Busy is set by the issue edge. A completion pulse clears busy only if the write grant for the current instruction has already been given. A completion that arrives earlier is ignored.
- R9: If a grant and a new issue edge reach the same unit in the same cycle, the issue wins. The flag stays armed, and the unit requests again in the next cycle.
- R10: A synchronous active-high reset clears every busy flag, every release flag and the stored issue level, so both grant vectors are zero after reset.
- R11: The read picker and the write picker act independently. A unit can receive a write grant while its read is blocked, in the same cycle that another unit receives a read grant.
- R12: When all N units are issued together with no dependencies, unit k receives its read grant in the k-th cycle after the requests appear. Every unit is granted within N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | N_UNITS | Issue level per unit; its rising edge starts an instruction |
| done_i | input | N_UNITS | Completion pulse per unit |
| rd_dep_i | input | N_UNITS x DEP_W | Pending read dependencies per unit |
| wr_dep_i | input | N_UNITS x DEP_W | Pending write dependencies per unit |
| go_rd_o | output | N_UNITS | One-hot read grant |
| go_wr_o | output | N_UNITS | One-hot write grant |
| busy_o | output | N_UNITS | Busy flag per unit |

## Verification
The main stimulus is two units issued together with no read dependencies while their writes stay blocked. This separates a correct single grant per unit from the repeated-grant starvation failure, and it also separates lowest-index priority from any other order. Later patterns keep a read blocked while the write is free, re-issue a unit in its own grant cycle, and hold issue high for several cycles. These tell picker independence, issue-over-grant priority and edge-only arming apart from a level-armed design. A last pattern issues all four units at once and checks that the read grants walk through the units in index order, one per cycle. Early completion pulses and a mid-run reset show that busy is released only after the write grant and that reset clears all state.

// File: rtl/sb_arb_pkg.sv
package sb_arb_pkg;

    localparam int DEF_UNITS = 4;
    localparam int DEF_DEP_W = 6;

    // Per-unit control state
    typedef struct packed {
        logic issue_q;   // issue level seen last cycle
        logic busy;      // instruction in flight
        logic rd_arm;    // read release flag
        logic wr_arm;    // write release flag
    } unit_state_t;

    // Request and grant pair for one unit
    typedef struct packed {
        logic rd;
        logic wr;
    } rw_pair_t;

    function automatic logic next_arm(input logic arm, input logic edge_set, input logic grant_clr);
        // issue edge outranks a grant in the same cycle
        if (edge_set)       return 1'b1;
        else if (grant_clr) return 1'b0;
        else                return arm;
    endfunction

endpackage

// File: rtl/sb_fixed_pick.sv
module sb_fixed_pick #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] grant_o
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_slot
            if (g == 0) begin : g_top
                assign grant_o[g] = req_i[g];
            end else begin : g_rest
                assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R4

    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~req_i) == '0); // R3

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (grant_o != '0) |-> ((req_i & (grant_o - ONE)) == '0)); // R3

    AST_NO_IDLE_PICK: assert property (@(posedge clk) disable iff (rst)
        (req_i != '0) |-> (grant_o != '0)); // R3

endmodule

// File: rtl/sb_unit_ctl.sv
module sb_unit_ctl
    import sb_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic done_i,
    input  logic rd_free_i,
    input  logic wr_free_i,
    input  logic go_rd_i,
    input  logic go_wr_i,
    output logic rd_req_o,
    output logic wr_req_o,
    output logic busy_o
);

    unit_state_t st;
    logic        issue_edge;
    logic        release_busy;

    assign issue_edge   = issue_i & ~st.issue_q;
    assign release_busy = done_i & ~st.wr_arm;

    assign rd_req_o = st.busy & st.rd_arm & rd_free_i;
    assign wr_req_o = st.busy & st.wr_arm & wr_free_i;
    assign busy_o   = st.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.issue_q <= issue_i;
            st.rd_arm  <= next_arm(st.rd_arm, issue_edge, go_rd_i);
            st.wr_arm  <= next_arm(st.wr_arm, issue_edge, go_wr_i);
            if (issue_edge)
                st.busy <= 1'b1;
            else if (release_busy)
                st.busy <= 1'b0;
        end
    end

    AST_GRANT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (go_rd_i || go_wr_i) |-> st.busy); // R2

    AST_RD_ONCE: assert property (@(posedge clk) disable iff (rst)
        (go_rd_i && !issue_edge) |=> !rd_req_o); // R5

    AST_WR_ONCE: assert property (@(posedge clk) disable iff (rst)
        (go_wr_i && !issue_edge) |=> !wr_req_o); // R6

    AST_HELD_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (issue_i && st.issue_q && !st.rd_arm) |=> !st.rd_arm); // R7

    AST_BUSY_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue_edge |=> st.busy); // R8

    AST_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
        (done_i && st.busy && st.wr_arm && !go_wr_i) |=> st.busy); // R8

    AST_ISSUE_BEATS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (go_rd_i && issue_edge) |=> st.rd_arm); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!st.busy && !st.rd_arm && !st.wr_arm)); // R10

endmodule

// File: rtl/sb_go_arbiter.sv
module sb_go_arbiter
    import sb_arb_pkg::*;
#(
    parameter int N_UNITS = DEF_UNITS,
    parameter int DEP_W   = DEF_DEP_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_UNITS-1:0]              issue_i,
    input  logic [N_UNITS-1:0]              done_i,
    input  logic [N_UNITS-1:0][DEP_W-1:0]   rd_dep_i,
    input  logic [N_UNITS-1:0][DEP_W-1:0]   wr_dep_i,
    output logic [N_UNITS-1:0]              go_rd_o,
    output logic [N_UNITS-1:0]              go_wr_o,
    output logic [N_UNITS-1:0]              busy_o
);

    rw_pair_t [N_UNITS-1:0] req;
    logic     [N_UNITS-1:0] rd_req_vec;
    logic     [N_UNITS-1:0] wr_req_vec;

    genvar u;
    generate
        for (u = 0; u < N_UNITS; u++) begin : g_unit
            logic rd_free;
            logic wr_free;
            assign rd_free = ~(|rd_dep_i[u]);
            assign wr_free = ~(|wr_dep_i[u]);

            sb_unit_ctl u_ctl (
                .clk       (clk),
                .rst       (rst),
                .issue_i   (issue_i[u]),
                .done_i    (done_i[u]),
                .rd_free_i (rd_free),
                .wr_free_i (wr_free),
                .go_rd_i   (go_rd_o[u]),
                .go_wr_i   (go_wr_o[u]),
                .rd_req_o  (req[u].rd),
                .wr_req_o  (req[u].wr),
                .busy_o    (busy_o[u])
            );

            assign rd_req_vec[u] = req[u].rd;
            assign wr_req_vec[u] = req[u].wr;

            AST_RD_DEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
                go_rd_o[u] |-> (rd_dep_i[u] == '0)); // R1

            AST_WR_DEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
                go_wr_o[u] |-> (wr_dep_i[u] == '0)); // R6
        end
    endgenerate

    sb_fixed_pick #(.WIDTH(N_UNITS)) u_rd_pick (
        .clk     (clk),
        .rst     (rst),
        .req_i   (rd_req_vec),
        .grant_o (go_rd_o)
    );

    sb_fixed_pick #(.WIDTH(N_UNITS)) u_wr_pick (
        .clk     (clk),
        .rst     (rst),
        .req_i   (wr_req_vec),
        .grant_o (go_wr_o)
    );

    AST_PICKERS_INDEPENDENT: assert property (@(posedge clk) disable iff (rst)
        ((rd_req_vec != '0) && (wr_req_vec != '0)) |-> ((go_rd_o != '0) && (go_wr_o != '0))); // R11

endmodule

// File: tb/sim_sb_go_arbiter.sv
module sim_sb_go_arbiter;

    localparam int  N       = 4;
    localparam int  DW      = 6;
    localparam time PERIOD  = 10;
    localparam int  N_ROWS  = 25;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [N-1:0]           issue_i;
    logic [N-1:0]           done_i;
    logic [N-1:0][DW-1:0]   rd_dep_i;
    logic [N-1:0][DW-1:0]   wr_dep_i;
    logic [N-1:0]           go_rd_o;
    logic [N-1:0]           go_wr_o;
    logic [N-1:0]           busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    sb_go_arbiter #(.N_UNITS(N), .DEP_W(DW)) u0 (
        .clk(clk), .rst(rst), .issue_i(issue_i), .done_i(done_i),
        .rd_dep_i(rd_dep_i), .wr_dep_i(wr_dep_i),
        .go_rd_o(go_rd_o), .go_wr_o(go_wr_o), .busy_o(busy_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // row: tag | issue | done | rd blocked | wr blocked | exp go_rd | exp go_wr
    localparam logic [27:0] TBL [N_ROWS] = '{
        {4'd2,  4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd2,  4'b0011, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd3,  4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0001, 4'b0000},
        {4'd12, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0010, 4'b0000},
        {4'd5,  4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd5,  4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd6,  4'b0000, 4'b0000, 4'b0000, 4'b1110, 4'b0000, 4'b0001},
        {4'd6,  4'b0000, 4'b0000, 4'b0000, 4'b1100, 4'b0000, 4'b0010},
        {4'd8,  4'b0000, 4'b0011, 4'b0000, 4'b1100, 4'b0000, 4'b0000},
        {4'd2,  4'b0100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd1,  4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0000, 4'b0100},
        {4'd11, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0000},
        {4'd2,  4'b1000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd1,  4'b0000, 4'b0000, 4'b1000, 4'b1111, 4'b0000, 4'b0000},
        {4'd9,  4'b1000, 4'b0000, 4'b0000, 4'b1111, 4'b1000, 4'b0000},
        {4'd9,  4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b1000, 4'b0000},
        {4'd5,  4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd7,  4'b1000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd7,  4'b1000, 4'b0000, 4'b0000, 4'b1111, 4'b1000, 4'b0000},
        {4'd7,  4'b1000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd7,  4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd8,  4'b0000, 4'b1000, 4'b0000, 4'b1111, 4'b0000, 4'b0000},
        {4'd8,  4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1000},
        {4'd8,  4'b0000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
        {4'd2,  4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}
    };

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // drive one cycle of stimulus at the falling edge, settle, leave sampling to caller
    task automatic step(input logic [N-1:0] iss, input logic [N-1:0] dn,
                        input logic [N-1:0] rblk, input logic [N-1:0] wblk);
        @(negedge clk);
        issue_i = iss;
        done_i  = dn;
        for (int k = 0; k < N; k++) begin
            rd_dep_i[k] = rblk[k] ? DW'(1 << (k % DW)) : '0;
            wr_dep_i[k] = wblk[k] ? DW'(1 << ((k + 1) % DW)) : '0;
        end
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        step('0, '0, '0, '0);
        step('0, '0, '0, '0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", busy_o,  '0, "busy after reset");
        check("R10", go_rd_o, '0, "go_rd after reset");
        check("R10", go_wr_o, '0, "go_wr after reset");

        for (int r = 0; r < N_ROWS; r++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", TBL[r][27:24], r);
            step(TBL[r][23:20], TBL[r][19:16], TBL[r][15:12], TBL[r][11:8]);
            check(tag, go_rd_o, TBL[r][7:4], "go_rd");
            check(tag, go_wr_o, TBL[r][3:0], "go_wr");
        end

        // R8: unit 3 released after its write grant, unit 2 still waiting for done
        check("R8", busy_o, 4'b0100, "busy after early and late done");
        step('0, 4'b0100, '0, '0);
        step('0, '0, '0, '0);
        check("R8", busy_o, 4'b0000, "busy after unit2 done");

        // R12: all units issued together, grants walk by index, one per cycle
        step(4'b1111, '0, '0, 4'b1111);
        check("R2", go_rd_o, 4'b0000, "no grant in issue cycle");
        step('0, '0, '0, 4'b1111);
        check("R12", go_rd_o, 4'b0001, "first of four");
        step('0, '0, '0, 4'b1111);
        check("R12", go_rd_o, 4'b0010, "second of four");
        step('0, '0, '0, 4'b1111);
        check("R12", go_rd_o, 4'b0100, "third of four");
        step('0, '0, '0, 4'b1111);
        check("R12", go_rd_o, 4'b1000, "fourth within N cycles");
        step('0, '0, '0, 4'b1111);
        check("R5", go_rd_o, 4'b0000, "no repeat read grants");
        check("R8", busy_o, 4'b1111, "all still busy");

        // R10: reset in the middle of pending writes
        @(negedge clk);
        rst = 1'b1;
        step('0, '0, '0, '0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", busy_o,  '0, "busy after mid-run reset");
        check("R10", go_wr_o, '0, "pending writes dropped by reset");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule